// File: doc/BRIEF.md
# CSI-2 Header Parameter Generator

This block sits beside a CSI-2 transmitter and supplies, from the sensor's own sync timing, the per-frame and per-line header fields that the transmitter would otherwise read from configuration registers. These fields are the virtual channel for the frame-start short packet, the virtual channel for the frame-end short packet, a frame counter shared by both short packets, and a 24-bit long-packet header.

A rising edge on `vsync` opens a frame. It clears the line index, advances the frame counter, and steps a three-phase exposure index through long, medium and short, which map to channels 0, 1 and 2. Each rising edge on `hsync` advances the line index. While the line index is below `blank_lines`, the header carries the blanking data type, and after that it carries the active data type. Typical settings are 10 blanking lines, blanking code 0x11 and RAW12 code 0x2C. Packet assembly and the transmission itself are handled elsewhere.

Top module: `csi2_hdr_param_gen`

## Requirements
- R1: While reset is held and just after it is released, `frame_count` is 0, the line index is 0, and the exposure index is 2 (short), so `fs_vc` reads 2 when `hdr_en` is 1.
- R2: `frame_count` increases by one on the clock edge that samples a `vsync` rising edge (sampled 1 after a sampled 0), and it wraps from all ones to 0.
- R3: The line index clears on a `vsync` rising edge and otherwise increases by one on each `hsync` rising edge. It saturates at 2^LINE_W-1. When both edges arrive in the same cycle, the `vsync` edge wins and the line index becomes 0.
- R4: With `blank_en` = 1, `lp_header[5:0]` equals `dt_blank` while the line index is less than `blank_lines`, and equals `dt_active` otherwise. A `blank_lines` value of 0 blanks no line.
- R5: With `blank_en` = 0, `lp_header[5:0]` equals `dt_active` on every line.
- R6: Each `vsync` rising edge steps the exposure index 0→1→2→0, so the first frame after reset uses channel 0. With `hdr_en` = 1, the channel output equals the exposure index.
- R7: With `hdr_en` = 0, the channel output equals `fixed_vc`. The exposure index keeps advancing on each frame, so the rotation resumes in step when `hdr_en` returns to 1.
- R8: `fs_vc`, `fe_vc` and `lp_header[7:6]` always carry the same channel value.
- R9: `lp_header` is laid out with the data type in bits [5:0], the virtual channel in bits [7:6] and `word_count` in bits [23:8].
- R10: Only edges count. A sync input held high for several cycles acts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical sync level; a rising edge starts a frame |
| hsync | input | 1 | Horizontal sync level; a rising edge starts a line |
| blank_en | input | 1 | Enables the blanking data type substitution |
| hdr_en | input | 1 | Selects the rotating exposure channel over `fixed_vc` |
| blank_lines | input | LINE_W | Number of leading blanking lines per frame |
| dt_blank | input | 6 | Data type code used on blanking lines |
| dt_active | input | 6 | Data type code used on all other lines |
| fixed_vc | input | 2 | Channel used when `hdr_en` is 0 |
| word_count | input | 16 | Long-packet word count, passed into the header |
| fs_vc | output | 2 | Frame-start virtual channel |
| fe_vc | output | 2 | Frame-end virtual channel |
| frame_count | output | FCNT_W | Frame counter for both short packets |
| lp_header | output | 24 | Long-packet header: {word count, channel, data type} |

## Verification
The bench builds the block with LINE_W = 4 and FCNT_W = 4. With these widths, frames of 20 lines drive the line index into saturation, where an unsaturated counter would wrap back into the blanking window. Twenty short frames also take the frame counter through its wrap. A behavioural model in the bench tracks the counters and the exposure phase, and the bench compares every output to this model on each clock. The stimulus covers coincident sync edges, sync levels held high, a blanking count of zero, and switching between the rotating channel and the fixed channel.

// File: rtl/csi2_hdr_param_gen.sv
module csi2_hdr_param_gen #(
  parameter int LINE_W = 12,
  parameter int FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              blank_en,
  input  logic              hdr_en,
  input  logic [LINE_W-1:0] blank_lines,
  input  logic [5:0]        dt_blank,
  input  logic [5:0]        dt_active,
  input  logic [1:0]        fixed_vc,
  input  logic [15:0]       word_count,
  output logic [1:0]        fs_vc,
  output logic [1:0]        fe_vc,
  output logic [FCNT_W-1:0] frame_count,
  output logic [23:0]       lp_header
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [1:0] EXP_LAST = 2'd2;

  logic              vs_q, hs_q;
  logic [LINE_W-1:0] line_idx;
  logic [1:0]        exp_idx;
  logic [1:0]        vc;
  logic [5:0]        dt;

  wire vs_rise = vsync & ~vs_q;
  wire hs_rise = hsync & ~hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q        <= 1'b0;
      hs_q        <= 1'b0;
      line_idx    <= '0;
      frame_count <= '0;
      exp_idx     <= EXP_LAST;
    end else begin
      vs_q <= vsync;
      hs_q <= hsync;
      if (vs_rise) begin
        line_idx    <= '0;
        frame_count <= frame_count + 1'b1;
        exp_idx     <= (exp_idx == EXP_LAST) ? 2'd0 : exp_idx + 2'd1;
      end else if (hs_rise && line_idx != LINE_MAX) begin
        line_idx <= line_idx + 1'b1;
      end
    end
  end

  assign vc        = hdr_en ? exp_idx : fixed_vc;
  assign dt        = (blank_en && line_idx < blank_lines) ? dt_blank : dt_active;
  assign fs_vc     = vc;
  assign fe_vc     = vc;
  assign lp_header = {word_count, vc, dt};
endmodule

module csi2_hdr_param_gen_chk #(
  parameter int FCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync,
  input logic              hdr_en,
  input logic              blank_en,
  input logic [5:0]        dt_blank,
  input logic [5:0]        dt_active,
  input logic [1:0]        fs_vc,
  input logic [FCNT_W-1:0] frame_count,
  input logic [23:0]       lp_header
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_count) |-> frame_count == $past(frame_count) + 1'b1);

  a_r2_count_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_count) |-> $past(vsync));

  a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_count) |-> !$past(vsync, 2));

  a_r6_vc_range: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_en |-> fs_vc != 2'd3);

  a_r6_vc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_en && $past(hdr_en) && !$stable(fs_vc)) |->
      fs_vc == (($past(fs_vc) == 2'd2) ? 2'd0 : $past(fs_vc) + 2'd1));

  a_r6_vc_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_en && $past(hdr_en) && !$stable(fs_vc)) |-> !$stable(frame_count));

  a_r4_dt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    lp_header[5:0] == dt_blank || lp_header[5:0] == dt_active);

  a_r5_no_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_en && dt_blank != dt_active) |-> lp_header[5:0] != dt_blank);
endmodule

bind csi2_hdr_param_gen csi2_hdr_param_gen_chk #(.FCNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .hdr_en(hdr_en), .blank_en(blank_en),
  .dt_blank(dt_blank), .dt_active(dt_active), .fs_vc(fs_vc),
  .frame_count(frame_count), .lp_header(lp_header)
);

// File: tb/csi2_hdr_param_gen_test.sv
module csi2_hdr_param_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 4;
  localparam int FCNT_W = 4;

  logic clk = 1'b0;
  logic rst_n, vsync, hsync, blank_en, hdr_en;
  logic [LINE_W-1:0] blank_lines;
  logic [5:0] dt_blank, dt_active;
  logic [1:0] fixed_vc;
  logic [15:0] word_count;
  logic [1:0] fs_vc, fe_vc;
  logic [FCNT_W-1:0] frame_count;
  logic [23:0] lp_header;

  int checks = 0, errors = 0;
  bit done = 0, model_live = 0;
  string cur = "R3";

  int m_vs, m_hs, m_line, m_fc, m_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  csi2_hdr_param_gen #(.LINE_W(LINE_W), .FCNT_W(FCNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .blank_en(blank_en),
    .hdr_en(hdr_en), .blank_lines(blank_lines), .dt_blank(dt_blank),
    .dt_active(dt_active), .fixed_vc(fixed_vc), .word_count(word_count),
    .fs_vc(fs_vc), .fe_vc(fe_vc), .frame_count(frame_count), .lp_header(lp_header));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vs = 0; m_hs = 0; m_line = 0; m_fc = 0; m_exp = 2;
      model_live = 1;
    end else begin
      if (vsync && !m_vs) begin
        m_line = 0;
        m_fc = (m_fc + 1) % (1 << FCNT_W);
        m_exp = (m_exp + 1) % 3;
      end else if (hsync && !m_hs && m_line < (1 << LINE_W) - 1) begin
        m_line = m_line + 1;
      end
      m_vs = vsync; m_hs = hsync;
    end
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      int evc, edt;
      evc = hdr_en ? m_exp : fixed_vc;
      edt = (blank_en && m_line < blank_lines) ? dt_blank : dt_active;
      chk({"R2 frame count (", cur, ")"}, frame_count, m_fc);
      chk(hdr_en ? "R6 fs channel" : "R7 fs channel", fs_vc, evc);
      chk("R8 fe channel", fe_vc, evc);
      chk("R8 header channel", lp_header[7:6], evc);
      chk({blank_en ? "R4" : "R5", " data type (", cur, ")"}, lp_header[5:0], edt);
      chk("R9 word count", lp_header[23:8], word_count);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int lines);
    vsync = 1; tick(1); vsync = 0; tick(1);
    for (int i = 0; i < lines; i++) begin
      word_count = 16'($urandom);
      hsync = 1; tick(1); hsync = 0; tick(2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; vsync = 0; hsync = 0; blank_en = 1; hdr_en = 1;
    blank_lines = 4'd10; dt_blank = 6'h11; dt_active = 6'h2C;
    fixed_vc = 2'd3; word_count = 16'd1920;
    tick(3);
    chk("R1 reset frame count", frame_count, 0);
    chk("R1 reset channel", fs_vc, 2);
    chk("R1 reset blank type", lp_header[5:0], 6'h11);
    rst_n = 1; tick(2);
    chk("R1 post-reset frame count", frame_count, 0);

    cur = "R3";  for (int f = 0; f < 3; f++) frame(14);
    chk("R6 after three frames channel", fs_vc, 2);
    cur = "R3";  frame(20);
    chk("R3 saturated line stays active", lp_header[5:0], 6'h2C);
    cur = "R4";  blank_lines = 0; frame(6);
    blank_lines = 3; dt_blank = 6'h12; dt_active = 6'h2A; frame(6);
    cur = "R5";  blank_en = 0; frame(6); blank_en = 1;
    cur = "R7";  hdr_en = 0; fixed_vc = 2'd3; frame(4); fixed_vc = 2'd1; frame(4);
    hdr_en = 1; tick(1);
    cur = "R10";
    vsync = 1; tick(4); vsync = 0; tick(1);
    hsync = 1; tick(3); hsync = 0; tick(1);
    hsync = 1; tick(1); hsync = 0; tick(2);
    cur = "R3";
    hsync = 1; tick(1); hsync = 0; tick(1);
    vsync = 1; hsync = 1; tick(1); vsync = 0; hsync = 0; tick(2);
    chk("R3 coincident edges blank line", lp_header[5:0], 6'h12);
    cur = "R2";  for (int f = 0; f < 20; f++) frame(1);
    tick(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule